// File: doc/BRIEF.md
# Motor Driver Fault Supervisor

This block sits between the protection sensors of a four-bridge motor driver and the bridge gate logic. It takes one current-limit flag for every power switch, an over-temperature flag, a supply-undervoltage flag, an active-low sleep input and an active-low chip reset input. From them it produces a single drive enable that gates every bridge, a request that returns the control registers to their initial values, and three sticky status bits.

Each fault class has its own recovery rule. A current-limit flag only becomes a fault when some flag stays set for a programmable number of consecutive clocks. Once qualified, it is held until the supply has been cycled. The supply cycle is seen as the undervoltage flag asserting and later clearing. Over-temperature shuts the drivers off at once and also waits for a supply cycle. That cycle only counts once the die has cooled. Undervoltage blocks the drivers only while it is present, and it also resets the control state. Sleep and chip reset gate the drive without clearing any latched fault.

Top module: `mdfs_top`

## Requirements
- R1: A qualified overcurrent occurs when at least one bit of `ilim_i` is 1 on QUAL_CYCLES consecutive rising clock edges. Any edge on which every bit is 0 restarts the count. With the default of 375, a flag held for 374 edges does not trip and a flag held for 375 edges does.
- R2: After a qualified overcurrent, `drive_en_o` stays 0 and `stat_oc_o` stays 1, even after every current-limit flag has cleared. Both are released only by `uv_i` going to 1.
- R3: While `ot_i` is 1, `drive_en_o` is 0 one clock later, and `stat_ot_o` is 1.
- R4: After `ot_i` clears, the over-temperature shutdown and `stat_ot_o` remain set. They are released only on a clock edge where `uv_i` is 1 and `ot_i` is 0. An undervoltage that occurs while `ot_i` is still 1 releases nothing.
- R5: While `uv_i` is 1, `drive_en_o` is 0. When it clears with no latched fault, `drive_en_o` returns to 1 one clock later without any other action.
- R6: While `uv_i` is 1, `regs_rst_o` is 1 and `stat_uv_o` is 1. Both are 0 one clock after `uv_i` clears.
- R7: When `rst_n_i` is 0, `drive_en_o` is 0 and `regs_rst_o` is 1. A latched overcurrent or over-temperature fault is not cleared by it.
- R8: When `sleep_n_i` is 0, `drive_en_o` is 0 and `regs_rst_o` stays 0. A latched fault is not cleared by it.
- R9: Every output is registered and follows its inputs one clock later. While `rst` is 1, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| ilim_i | input | N_BRIDGE*SW_PER_BRIDGE | Analog current-limit flag per power switch, bridge-major |
| ot_i | input | 1 | Over-temperature flag |
| uv_i | input | 1 | Supply undervoltage flag |
| sleep_n_i | input | 1 | Active-low sleep request |
| rst_n_i | input | 1 | Active-low chip reset request |
| drive_en_o | output | 1 | Global enable for all bridges |
| regs_rst_o | output | 1 | Request to return control registers to initial values |
| stat_oc_o | output | 1 | Sticky qualified-overcurrent status |
| stat_ot_o | output | 1 | Sticky over-temperature status |
| stat_uv_o | output | 1 | Undervoltage status |

## Verification
The hardest situation to reach is the exact edge of the qualification window. The flag must be held for one edge short of the limit and then for exactly the limit. It must also be interrupted for a single cycle just before the limit would be reached. The bench drives `ilim_i` for counted clock cycles and samples `drive_en_o` one cycle after the final edge. The second hardest case is an undervoltage pulse that arrives while over-temperature is still active. The bench holds `ot_i` high across that pulse, then confirms the fault stays latched until a second pulse arrives after cooling.

// File: rtl/mdfs_pkg.sv
package mdfs_pkg;

    typedef struct packed {
        logic oc;
        logic ot;
        logic uv;
    } fault_stat_t;

    // Drive is allowed only with no blocking condition present.
    function automatic logic drive_allowed(
        input logic        uv,
        input logic        ot,
        input logic        sleep_n,
        input logic        chip_rst_n,
        input fault_stat_t latched,
        input logic        oc_trip
    );
        return !uv && !ot && sleep_n && chip_rst_n &&
               !latched.oc && !latched.ot && !oc_trip;
    endfunction

endpackage

// File: rtl/mdfs_ilim_qual.sv
module mdfs_ilim_qual #(
    parameter int N_BRIDGE      = 4,
    parameter int SW_PER_BRIDGE = 4,
    parameter int QUAL_CYCLES   = 375
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [N_BRIDGE*SW_PER_BRIDGE-1:0] ilim,
    output logic                              trip
);
    localparam int CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

    logic [N_BRIDGE-1:0] br_any;
    logic                any_flag;
    logic [CW-1:0]       cnt_q;

    for (genvar b = 0; b < N_BRIDGE; b++) begin : g_br
        assign br_any[b] = |ilim[b*SW_PER_BRIDGE +: SW_PER_BRIDGE];
    end

    assign any_flag = |br_any;
    assign trip     = any_flag && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !any_flag)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    p_cnt_restart_r1: assert property (@(posedge clk) disable iff (rst)
        !any_flag |=> (cnt_q == '0));
    p_trip_needs_run_r1: assert property (@(posedge clk) disable iff (rst)
        (trip && QUAL_CYCLES > 1) |-> $past(any_flag));

endmodule

// File: rtl/mdfs_fault_latch.sv
module mdfs_fault_latch (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 oc_trip,
    input  logic                 ot,
    input  logic                 uv,
    output mdfs_pkg::fault_stat_t lat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lat <= '0;
        end else begin
            // Supply cycle (uv) releases overcurrent unconditionally.
            lat.oc <= uv ? 1'b0 : (lat.oc | oc_trip);
            // Over-temperature only released by a supply cycle after cooling.
            if (ot)
                lat.ot <= 1'b1;
            else if (uv)
                lat.ot <= 1'b0;
            lat.uv <= uv;
        end
    end

    p_oc_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (lat.oc && !uv) |=> lat.oc);
    p_ot_hot_hold_r4: assert property (@(posedge clk) disable iff (rst)
        ot |=> lat.ot);
    p_ot_release_r4: assert property (@(posedge clk) disable iff (rst)
        (lat.ot && !uv) |=> lat.ot);

endmodule

// File: rtl/mdfs_top.sv
module mdfs_top #(
    parameter int N_BRIDGE      = 4,
    parameter int SW_PER_BRIDGE = 4,
    parameter int QUAL_CYCLES   = 375
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [N_BRIDGE*SW_PER_BRIDGE-1:0] ilim_i,
    input  logic                              ot_i,
    input  logic                              uv_i,
    input  logic                              sleep_n_i,
    input  logic                              rst_n_i,
    output logic                              drive_en_o,
    output logic                              regs_rst_o,
    output logic                              stat_oc_o,
    output logic                              stat_ot_o,
    output logic                              stat_uv_o
);
    import mdfs_pkg::*;

    logic        oc_trip;
    fault_stat_t lat;
    logic        en_q;
    logic        rr_q;

    mdfs_ilim_qual #(
        .N_BRIDGE      (N_BRIDGE),
        .SW_PER_BRIDGE (SW_PER_BRIDGE),
        .QUAL_CYCLES   (QUAL_CYCLES)
    ) u_qual (
        .clk  (clk),
        .rst  (rst),
        .ilim (ilim_i),
        .trip (oc_trip)
    );

    mdfs_fault_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .oc_trip (oc_trip),
        .ot      (ot_i),
        .uv      (uv_i),
        .lat     (lat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            rr_q <= 1'b0;
        end else begin
            en_q <= drive_allowed(uv_i, ot_i, sleep_n_i, rst_n_i, lat, oc_trip);
            rr_q <= uv_i || !rst_n_i;
        end
    end

    assign drive_en_o = en_q;
    assign regs_rst_o = rr_q;
    assign stat_oc_o  = lat.oc;
    assign stat_ot_o  = lat.ot;
    assign stat_uv_o  = lat.uv;

    p_latched_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        (stat_oc_o || stat_ot_o) |=> !drive_en_o);
    p_uv_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        uv_i |=> (!drive_en_o && regs_rst_o && stat_uv_o));
    p_sleep_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        !sleep_n_i |=> !drive_en_o);
    p_chip_rst_r7: assert property (@(posedge clk) disable iff (rst)
        !rst_n_i |=> (!drive_en_o && regs_rst_o));

endmodule

// File: tb/mdfs_top_tb.sv
module mdfs_top_tb;
    localparam int NB   = 4;
    localparam int NS   = 4;
    localparam int NF   = NB * NS;
    localparam int QUAL = 375;

    logic          clk = 1'b0;
    logic          rst;
    logic [NF-1:0] ilim;
    logic          ot, uv, sleep_n, rst_n;
    logic          en, rr, s_oc, s_ot, s_uv;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mdfs_top #(.N_BRIDGE(NB), .SW_PER_BRIDGE(NS), .QUAL_CYCLES(QUAL)) u_dut (
        .clk(clk), .rst(rst), .ilim_i(ilim), .ot_i(ot), .uv_i(uv),
        .sleep_n_i(sleep_n), .rst_n_i(rst_n), .drive_en_o(en),
        .regs_rst_o(rr), .stat_oc_o(s_oc), .stat_ot_o(s_ot), .stat_uv_o(s_uv)
    );

    // vector: {uv, sleep_n, rst_n, ilim_bit, exp_en, exp_rr}
    localparam int NV = 7;
    localparam logic [5:0] VEC [NV] = '{
        6'b0_1_1_0_1_0,   // R5 normal drive
        6'b0_0_1_0_0_0,   // R8 sleep blocks, no reg reset
        6'b0_1_0_0_0_1,   // R7 chip reset
        6'b1_1_1_0_0_1,   // R5 R6 undervoltage
        6'b0_1_1_1_1_0,   // R1 single-cycle flag does not trip
        6'b0_0_0_0_0_1,   // R7 R8 combined
        6'b1_0_1_1_0_1    // R6 uv with sleep
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic idle();
        ilim = '0; ot = 0; uv = 0; sleep_n = 1; rst_n = 1;
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        rst = 1; idle();
        step(3);
        // R9 reset state
        check("R9 en", en, 0); check("R9 rr", rr, 0);
        check("R9 oc", s_oc, 0); check("R9 ot", s_ot, 0); check("R9 uv", s_uv, 0);
        rst = 0;
        step(1);
        check("R9 en after 1 clk", en, 1);

        for (int i = 0; i < NV; i++) begin
            uv = VEC[i][5]; sleep_n = VEC[i][4]; rst_n = VEC[i][3];
            ilim = '0; ilim[(i*3) % NF] = VEC[i][2];
            step(1);
            check($sformatf("R5-table en v%0d", i), en, VEC[i][1]);
            check($sformatf("R6-table rr v%0d", i), rr, VEC[i][0]);
            check($sformatf("R6-table uv v%0d", i), s_uv, VEC[i][5]);
            idle(); step(1);
            check($sformatf("R5 resume v%0d", i), en, 1);
        end

        // R1 one edge short
        ilim = '0; ilim[NF-1] = 1;
        step(QUAL - 1);
        ilim = '0; step(1);
        check("R1 short no trip en", en, 1);
        check("R1 short no trip oc", s_oc, 0);

        // R1 interrupted run restarts count
        ilim[5] = 1; step(QUAL - 10);
        ilim = '0; step(1);
        ilim[9] = 1; step(QUAL - 10);
        ilim = '0; step(1);
        check("R1 restart en", en, 1);
        check("R1 restart oc", s_oc, 0);

        // R1 exact limit trips; several flags on different bridges
        ilim[0] = 1; ilim[7] = 1;
        step(QUAL - 1);
        check("R1 before limit en", en, 1);
        step(1);
        check("R1 trip en", en, 0);
        check("R2 trip oc", s_oc, 1);
        ilim = '0; step(5);
        check("R2 held en", en, 0);
        check("R2 held oc", s_oc, 1);

        // R7/R8 do not clear latched overcurrent
        rst_n = 0; step(2); rst_n = 1; step(1);
        check("R7 keep oc", s_oc, 1);
        check("R7 keep en off", en, 0);
        sleep_n = 0; step(2); sleep_n = 1; step(1);
        check("R8 keep oc", s_oc, 1);
        check("R8 rr stays 0", rr, 0);

        // R2 supply cycle releases
        uv = 1; step(1);
        check("R2 uv clears oc", s_oc, 0);
        check("R6 rr", rr, 1);
        uv = 0; step(1);
        check("R2 en after cycle", en, 1);
        check("R6 rr clears", rr, 0);
        check("R6 uv clears", s_uv, 0);

        // R3 over-temperature
        ot = 1; step(1);
        check("R3 en", en, 0); check("R3 stat", s_ot, 1);
        step(3);
        ot = 0; step(3);
        check("R4 held en", en, 0); check("R4 held stat", s_ot, 1);
        // R4 uv while still hot does not release
        ot = 1; uv = 1; step(2); uv = 0; step(1); ot = 0; step(2);
        check("R4 hot uv no release", s_ot, 1);
        check("R4 hot uv en", en, 0);
        // R4 uv after cooling releases
        uv = 1; step(1); uv = 0; step(1);
        check("R4 release stat", s_ot, 0);
        check("R4 release en", en, 1);

        // R9 reset mid-fault clears outputs
        ilim[3] = 1; step(QUAL + 2);
        check("R2 second trip", s_oc, 1);
        rst = 1; step(1);
        check("R9 rst en", en, 0); check("R9 rst oc", s_oc, 0);
        rst = 0; ilim = '0; step(1);
        check("R9 after rst en", en, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule